// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable, device-side model of a small serial EEPROM. It stores 64 words of 16 bits in an internal register file. A host talks to it over three wires: a select line, a serial clock and a data input. The model answers on one data output. The block runs from a fast system clock, samples the serial wires with that clock, and acts on each rising edge of the serial clock it detects while select is high. The serial wires are expected to be synchronous to the system clock, or already synchronized to it.

Each command begins with a 1 start bit. A 2-bit operation code follows, then a 6-bit word address. Reads return a dummy zero and then the word. Writes carry 16 data bits after the address. Erase operations set bits to 1, and two special codes act on the whole array. Every change to the array needs a prior unlock, and a lock is in force after reset. An accepted change starts a self-timed busy interval of `PROG_CYCLES` system clocks. A host can poll this interval by dropping select and raising it again.

Top module: `serial_eeprom_model`

## Requirements
- R1: After reset, programming is locked, `doOut` is 0 and every stored word reads 16'hFFFF.
- R2: While select is high, zeros sampled before the first 1 on `diIn` are ignored. That 1 is the start bit. The next 8 bits are sampled on rising serial clock edges, MSB first: the operation code (2 bits), then the address A5..A0.
- R3: Operation code 2'b10 reads the addressed word. After the last address bit, `doOut` shows a dummy 0. Each later rising serial clock edge then moves the next data bit onto `doOut`, MSB first.
- R4: Operation code 2'b01 writes the addressed word with the 16 bits that follow the address, MSB first. The busy interval starts as soon as the last data bit has been received.
- R5: Operation code 2'b11 sets every bit of the addressed word to 1.
- R6: Operation code 2'b00 with address bits A5..A4 = 2'b11 unlocks programming, and 2'b00 locks it. The state holds until the opposite command or a reset.
- R7: Operation code 2'b00 with A5..A4 = 2'b10 sets every word to 16'hFFFF. With A5..A4 = 2'b01, the 16 data bits that follow are written into every word.
- R8: A write, erase, full erase or full write received while locked leaves the array unchanged and starts no busy interval.
- R9: After an accepted change, the array is busy for `PROG_CYCLES` system clocks. If select goes low and then high during that time, `doOut` shows 0 while busy and 1 once the interval has ended.
- R10: If select is raised only after the busy interval has ended, `doOut` stays 0.
- R11: Any command started during the busy interval is ignored, including unlock and lock.
- R12: Select low aborts any partial command within one system clock. The model then waits for a new start bit, and `doOut` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock; its rising edges are sampled |
| diIn | input | 1 | Serial data into the model |
| doOut | output | 1 | Serial data out, read data or ready/busy |

## Verification
The hardest state to reach is the ready/busy poll. It needs a programming command that was accepted, a select drop and rise inside the busy window, and then a second command arriving in that same window. The bench counts serial clocks so that it unlocks, writes, and then toggles select right after the last data bit. It samples busy, sends a lock and a second write while still busy, and then waits for ready. Reads taken afterwards show whether the ignored commands really changed nothing: the lock must not have taken hold, and the second word must still hold its old value.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  typedef struct packed {
    logic shiftIn;    // capture diIn into the input shift register
    logic loadRead;   // load the read word and drive the dummy zero
    logic shiftOut;   // advance the read word by one bit
    logic progStart;  // begin a self-timed change of the array
    logic progAll;    // the change targets every word
    logic progErase;  // the change sets bits to one
  } strobe_t;

  typedef enum logic [1:0] {
    DO_ZERO,
    DO_DATA,
    DO_STATUS
  } do_sel_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DECODE,
    ST_DATA,
    ST_COMMIT,
    ST_READ,
    ST_DONE
  } ctrl_state_t;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
  import seeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csIn,
  input  logic                   skIn,
  input  logic                   diIn,
  input  logic                   busy,
  input  logic [ADDR_W+1:0]      cmdWord,
  output strobe_t                strb,
  output do_sel_t                doSel
);

  localparam int CMD_BITS = ADDR_W + 2;
  localparam int CNT_W    = $clog2(CMD_BITS + DATA_W);

  ctrl_state_t      state;
  logic [CNT_W-1:0] bitCnt;
  logic             skPrev;
  logic             csPrev;
  logic             progEnable;
  logic             statusMode;
  logic             readPhase;
  logic             isAll;

  logic             skRise;
  logic [1:0]       opCode;
  logic [1:0]       subCode;

  assign skRise  = skIn & ~skPrev;
  assign opCode  = cmdWord[CMD_BITS-1 -: 2];
  assign subCode = cmdWord[ADDR_W-1 -: 2];

  always_comb begin
    strb = '0;
    if (csIn) begin
      case (state)
        ST_CMD, ST_DATA: strb.shiftIn = skRise;
        ST_READ:         strb.shiftOut = skRise;
        ST_DECODE: begin
          if (opCode == OP_READ) begin
            strb.loadRead = 1'b1;
          end else if (opCode == OP_ERASE && progEnable) begin
            strb.progStart = 1'b1;
            strb.progErase = 1'b1;
          end else if (opCode == OP_SPECIAL && subCode == SUB_CLEAR && progEnable) begin
            strb.progStart = 1'b1;
            strb.progErase = 1'b1;
            strb.progAll   = 1'b1;
          end
        end
        ST_COMMIT: begin
          if (progEnable) begin
            strb.progStart = 1'b1;
            strb.progAll   = isAll;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (statusMode)     doSel = DO_STATUS;
    else if (readPhase) doSel = DO_DATA;
    else                doSel = DO_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      skPrev     <= 1'b0;
      csPrev     <= 1'b0;
      progEnable <= 1'b0;
      statusMode <= 1'b0;
      readPhase  <= 1'b0;
      isAll      <= 1'b0;
    end else begin
      skPrev <= skIn;
      csPrev <= csIn;
      if (!csIn) begin
        state      <= ST_IDLE;
        bitCnt     <= '0;
        statusMode <= 1'b0;
        readPhase  <= 1'b0;
      end else begin
        if (!csPrev && busy) statusMode <= 1'b1;
        case (state)
          ST_IDLE: begin
            if (skRise && diIn && !busy) begin
              state      <= ST_CMD;
              bitCnt     <= '0;
              statusMode <= 1'b0;
            end
          end
          ST_CMD: begin
            if (skRise) begin
              if (bitCnt == CNT_W'(CMD_BITS - 1)) state <= ST_DECODE;
              else bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_DECODE: begin
            bitCnt <= '0;
            state  <= ST_DONE;
            case (opCode)
              OP_READ: begin
                state     <= ST_READ;
                readPhase <= 1'b1;
              end
              OP_WRITE: begin
                state <= ST_DATA;
                isAll <= 1'b0;
              end
              OP_SPECIAL: begin
                case (subCode)
                  SUB_UNLOCK: progEnable <= 1'b1;
                  SUB_LOCK:   progEnable <= 1'b0;
                  SUB_FILL: begin
                    state <= ST_DATA;
                    isAll <= 1'b1;
                  end
                  default: ;
                endcase
              end
              default: ;
            endcase
          end
          ST_DATA: begin
            if (skRise) begin
              if (bitCnt == CNT_W'(DATA_W - 1)) state <= ST_COMMIT;
              else bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_COMMIT: state <= ST_DONE;
          ST_READ: begin
            if (skRise) begin
              if (bitCnt == CNT_W'(DATA_W - 1)) state <= ST_DONE;
              else bitCnt <= bitCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: the array only changes while programming is unlocked
  a_r8_locked_no_prog: assert property (@(posedge clk) disable iff (!rstN)
    strb.progStart |-> progEnable);

  // R11: no new change may begin inside a busy interval
  a_r11_no_prog_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.progStart);

  // R12: select low returns the control to idle with no status shown
  a_r12_cs_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> (state == ST_IDLE && !statusMode && !readPhase));

  // R10: status display only begins while the array is busy
  a_r10_status_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusMode) |-> $past(busy));

endmodule

// File: rtl/seeprom_datapath.sv
module seeprom_datapath
  import seeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              diIn,
  input  strobe_t           strb,
  input  do_sel_t           doSel,
  output logic              busy,
  output logic [ADDR_W+1:0] cmdWord,
  output logic              doOut
);

  localparam int CMD_BITS = ADDR_W + 2;
  localparam int SR_W     = CMD_BITS + DATA_W;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int BUSY_W   = $clog2(PROG_CYCLES + 1);

  logic [SR_W-1:0]   inShift;
  logic [DATA_W-1:0] outShift;
  logic              doBit;
  logic [BUSY_W-1:0] busyCnt;
  logic [DATA_W-1:0] memArr [DEPTH];

  logic [ADDR_W-1:0] cmdAddr;
  logic [ADDR_W-1:0] dataAddr;
  logic [ADDR_W-1:0] progAddr;
  logic [DATA_W-1:0] progVal;

  assign cmdWord  = inShift[CMD_BITS-1:0];
  assign cmdAddr  = inShift[ADDR_W-1:0];
  assign dataAddr = inShift[DATA_W +: ADDR_W];
  // erase commands finish at decode, write commands after their data
  assign progAddr = strb.progErase ? cmdAddr : dataAddr;
  assign progVal  = strb.progErase ? {DATA_W{1'b1}} : inShift[DATA_W-1:0];
  assign busy     = (busyCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift <= '0;
    end else if (strb.shiftIn) begin
      inShift <= {inShift[SR_W-2:0], diIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
      doBit    <= 1'b0;
    end else if (strb.loadRead) begin
      outShift <= memArr[cmdAddr];
      doBit    <= 1'b0;
    end else if (strb.shiftOut) begin
      doBit    <= outShift[DATA_W-1];
      outShift <= {outShift[DATA_W-2:0], 1'b0};
    end
  end

  generate
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN) begin
          memArr[w] <= {DATA_W{1'b1}};
        end else if (strb.progStart && (strb.progAll || progAddr == ADDR_W'(w))) begin
          memArr[w] <= progVal;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strb.progStart) begin
      busyCnt <= BUSY_W'(PROG_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_comb begin
    case (doSel)
      DO_STATUS: doOut = ~busy;
      DO_DATA:   doOut = doBit;
      default:   doOut = 1'b0;
    endcase
  end

  // R9: a busy interval is always opened by an accepted change
  a_r9_busy_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.progStart));

  // R3: the cycle after a read is decoded the output bit is the dummy zero
  a_r3_dummy_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadRead) |-> !doBit);

  // R9: the busy counter never exceeds the programmed length
  a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= BUSY_W'(PROG_CYCLES));

endmodule

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model
  import seeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut
);

  strobe_t           strb;
  do_sel_t           doSel;
  logic              busy;
  logic [ADDR_W+1:0] cmdWord;

  seeprom_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csIn    (csIn),
    .skIn    (skIn),
    .diIn    (diIn),
    .busy    (busy),
    .cmdWord (cmdWord),
    .strb    (strb),
    .doSel   (doSel)
  );

  seeprom_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .diIn    (diIn),
    .strb    (strb),
    .doSel   (doSel),
    .busy    (busy),
    .cmdWord (cmdWord),
    .doOut   (doOut)
  );

endmodule

// File: tb/tb_serial_eeprom_model.sv
module tb_serial_eeprom_model;

  localparam int PROG = 200;

  // vector kinds
  localparam logic [3:0] K_READ  = 4'd0;
  localparam logic [3:0] K_WRITE = 4'd1;
  localparam logic [3:0] K_ERASE = 4'd2;
  localparam logic [3:0] K_OPEN  = 4'd3;
  localparam logic [3:0] K_SHUT  = 4'd4;
  localparam logic [3:0] K_CLEAR = 4'd5;
  localparam logic [3:0] K_FILL  = 4'd6;

  // {kind, addr, data, expected read, requirement number}
  localparam int NVEC = 20;
  localparam logic [45:0] VEC [NVEC] = '{
    {K_READ,  6'd5,  16'h0000, 16'hFFFF, 4'd1},  // R1 erased after reset
    {K_WRITE, 6'd5,  16'h1234, 16'h0000, 4'd8},  // R8 locked write
    {K_READ,  6'd5,  16'h0000, 16'hFFFF, 4'd8},
    {K_OPEN,  6'd0,  16'h0000, 16'h0000, 4'd6},  // R6 unlock
    {K_WRITE, 6'd5,  16'hA5C3, 16'h0000, 4'd4},  // R4
    {K_READ,  6'd5,  16'h0000, 16'hA5C3, 4'd4},
    {K_WRITE, 6'd63, 16'h8001, 16'h0000, 4'd4},
    {K_READ,  6'd63, 16'h0000, 16'h8001, 4'd3},  // R3 top address
    {K_WRITE, 6'd0,  16'h0000, 16'h0000, 4'd4},
    {K_READ,  6'd0,  16'h0000, 16'h0000, 4'd3},
    {K_ERASE, 6'd5,  16'h0000, 16'h0000, 4'd5},  // R5
    {K_READ,  6'd5,  16'h0000, 16'hFFFF, 4'd5},
    {K_FILL,  6'd0,  16'h3C3C, 16'h0000, 4'd7},  // R7 fill
    {K_READ,  6'd17, 16'h0000, 16'h3C3C, 4'd7},
    {K_READ,  6'd63, 16'h0000, 16'h3C3C, 4'd7},
    {K_CLEAR, 6'd0,  16'h0000, 16'h0000, 4'd7},  // R7 clear
    {K_READ,  6'd0,  16'h0000, 16'hFFFF, 4'd7},
    {K_SHUT,  6'd0,  16'h0000, 16'h0000, 4'd6},  // R6 lock
    {K_WRITE, 6'd9,  16'h0F0F, 16'h0000, 4'd6},
    {K_READ,  6'd9,  16'h0000, 16'hFFFF, 4'd6}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0;
  logic skIn = 1'b0;
  logic diIn = 1'b0;
  logic doOut;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  serial_eeprom_model #(.PROG_CYCLES(PROG)) dut (
    .clk  (clk),
    .rstN (rstN),
    .csIn (csIn),
    .skIn (skIn),
    .diIn (diIn),
    .doOut(doOut)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); diIn = b;
    idle(1); skIn = 1'b1;
    idle(2); skIn = 1'b0;
    idle(1);
  endtask

  task automatic csLow();
    @(negedge clk); csIn = 1'b0; diIn = 1'b0;
    idle(3);
  endtask

  task automatic csHigh();
    @(negedge clk); csIn = 1'b1;
    idle(2);
  endtask

  task automatic header(input logic [1:0] op, input logic [5:0] addr);
    csHigh();
    sendBit(1'b1);
    for (int i = 1; i >= 0; i--) sendBit(op[i]);
    for (int i = 5; i >= 0; i--) sendBit(addr[i]);
  endtask

  task automatic sendData(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) sendBit(d[i]);
  endtask

  task automatic readWord(input logic [5:0] addr, output logic dummy, output logic [15:0] w);
    header(2'b10, addr);
    dummy = doOut;
    for (int i = 15; i >= 0; i--) begin
      sendBit(1'b0);
      w[i] = doOut;
    end
    csLow();
  endtask

  task automatic waitProg();
    idle(PROG + 20);
  endtask

  task automatic runVec(input logic [45:0] v);
    logic [3:0] kind;
    logic [5:0] addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0] req;
    logic dummy;
    logic [15:0] w;
    {kind, addr, data, exp, req} = v;
    case (kind)
      K_READ: begin
        readWord(addr, dummy, w);
        check($sformatf("R%0d read dummy bit", req), {15'd0, dummy}, 16'd0);
        check($sformatf("R%0d read word %0d", req, addr), w, exp);
      end
      K_WRITE: begin header(2'b01, addr); sendData(data); csLow(); waitProg(); end
      K_ERASE: begin header(2'b11, addr); csLow(); waitProg(); end
      K_OPEN:  begin header(2'b00, 6'b110000); csLow(); end
      K_SHUT:  begin header(2'b00, 6'b000000); csLow(); end
      K_CLEAR: begin header(2'b00, 6'b100000); csLow(); waitProg(); end
      K_FILL:  begin header(2'b00, 6'b010000); sendData(data); csLow(); waitProg(); end
      default: ;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic dummy;
    logic [15:0] w;
    idle(4);
    check("R1 doOut in reset", {15'd0, doOut}, 16'd0);
    rstN = 1'b1;
    idle(2);
    check("R1 doOut after reset", {15'd0, doOut}, 16'd0);

    for (int k = 0; k < NVEC; k++) runVec(VEC[k]);

    // unlock again for the directed part
    header(2'b00, 6'b111111); csLow();

    // R2: leading zeros before the start bit
    csHigh();
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    sendBit(1'b1);
    sendBit(1'b0); sendBit(1'b1);
    for (int i = 5; i >= 0; i--) sendBit(i == 0);  // address 1
    sendData(16'hBEEF);
    csLow(); waitProg();
    readWord(6'd1, dummy, w);
    check("R2 leading zeros ignored", w, 16'hBEEF);

    // R12: aborted command leaves no trace and DO returns low
    header(2'b10, 6'd1);
    check("R3 dummy zero before data", {15'd0, doOut}, 16'd0);
    sendBit(1'b0);
    check("R3 first data bit is MSB", {15'd0, doOut}, 16'd1);
    @(negedge clk); csIn = 1'b0;
    idle(2);
    check("R12 doOut low with select low", {15'd0, doOut}, 16'd0);
    idle(2);
    csHigh();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);  // write opcode
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);  // partial address
    csLow();
    readWord(6'd1, dummy, w);
    check("R12 aborted write left word 1", w, 16'hBEEF);

    // R9 / R11: status poll and commands during busy
    header(2'b01, 6'd20); sendData(16'h1357);
    csLow(); csHigh();
    check("R9 busy shows 0", {15'd0, doOut}, 16'd0);
    csLow();
    header(2'b00, 6'b000000); csLow();            // lock, ignored (R11)
    header(2'b01, 6'd21); sendData(16'h0000);     // write, ignored (R11)
    csHigh();
    idle(PROG + 20);
    check("R9 ready shows 1", {15'd0, doOut}, 16'd1);
    csLow();

    // R10: select raised after the interval gives no status
    csHigh();
    check("R10 no status after end", {15'd0, doOut}, 16'd0);
    csLow();

    readWord(6'd20, dummy, w);
    check("R4 word 20 written", w, 16'h1357);
    readWord(6'd21, dummy, w);
    check("R11 write during busy ignored", w, 16'hFFFF);
    header(2'b01, 6'd22); sendData(16'h00FF); csLow(); waitProg();
    readWord(6'd22, dummy, w);
    check("R11 lock during busy ignored", w, 16'h00FF);

    // R8: a locked write starts no busy interval
    header(2'b00, 6'b000000); csLow();
    header(2'b11, 6'd22); csLow(); csHigh();
    check("R8 no busy when locked", {15'd0, doOut}, 16'd0);
    csLow();
    readWord(6'd22, dummy, w);
    check("R8 locked erase no effect", w, 16'h00FF);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule